// File: doc/BRIEF.md
# Multi-Input Event Packet Merger

This block gathers one event packet from each of up to `N_IN` input links and emits them as a single merged packet. Each link delivers words over a valid/data/last stream with a per-input ready signal. A mask input selects which links take part in the event. When every selected link has delivered its end-of-packet word, the block drains its per-input stores one after another in ascending input index. Each input's data is preceded by a header word that gives the input's index and word count.

Alongside the merge, the block keeps per-input arrival timing. A cycle timer restarts on every accept strobe (`l1a`). The timer value is latched when each input's packet begins, when it ends, and when the final input of the event is stored. Each new accept strobe moves the current-event set into a previous-event set, so two events of timing stay readable on the output ports.

Top module: `pkt_merger`

## Requirements
- R1: An input whose `enable_mask` bit is 0 is ignored. Its `in_ready` stays low, none of its words appear at the output, and its current begin and end timestamps stay 0.
- R2: After an input's word marked `in_last` is accepted, that input's `in_ready` stays low until the merged output packet that contains it has been emitted.
- R3: Packets of 1 to `DEPTH` words are stored whole. `in_ready` is low while an input's store holds `DEPTH` words.
- R4: The output packet starts only after every enabled input has delivered its last word. Each completed set yields exactly one output packet.
- R5: The output carries the enabled inputs in ascending index. Each input contributes a header word followed by its data words in arrival order. The header has the word count in bits [15:0], the input index in bits [16+IDX_W-1:16], and zeros in all other bits.
- R6: `out_valid` stays high on consecutive cycles from the first header to the packet's final word. `out_last` is high only on the final data word of the highest enabled input.
- R7: The timer reads 0 in the cycle `l1a` is high. It rises by one each later cycle and holds at its all-ones value.
- R8: An input's begin timestamp is the timer value in the cycle its first packet word is accepted. Its end timestamp is the timer value in the cycle its last word is accepted.
- R9: The final-store timestamp is the timer value in the cycle in which the last word that completes the enabled set is accepted.
- R10: On `l1a`, every current timestamp moves to its previous-event counterpart and the current timestamps return to 0.
- R11: After reset, `out_valid` and `out_last` are low, all timestamps are 0, and `in_ready` is high for every enabled input.
- R12: With `enable_mask` all zero, no output word is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_mask | input | N_IN | Per-input participation mask |
| l1a | input | 1 | Accept strobe that opens an event and restarts the timer |
| in_valid | input | N_IN | Per-input word valid |
| in_data | input | N_IN*DATA_W | Per-input data, input i in slice i |
| in_last | input | N_IN | Per-input end-of-packet marker |
| in_ready | output | N_IN | Per-input ready |
| out_valid | output | 1 | Merged word valid |
| out_data | output | DATA_W | Merged word |
| out_last | output | 1 | Final word of the merged packet |
| cur_begin_ts | output | N_IN*TS_W | Current-event begin times |
| cur_end_ts | output | N_IN*TS_W | Current-event end times |
| prev_begin_ts | output | N_IN*TS_W | Previous-event begin times |
| prev_end_ts | output | N_IN*TS_W | Previous-event end times |
| cur_final_ts | output | TS_W | Current-event final-store time |
| prev_final_ts | output | TS_W | Previous-event final-store time |

## Verification
The bench builds the block with `N_IN`=4, `DATA_W`=32, `DEPTH`=8 and `TS_W`=8. The 8-bit timer lets a 300-cycle wait reach saturation at 255, which checks R7 without long runs. The 8-entry store means a packet of full depth is cheap to send, so the full-store ready behaviour is exercised. Inputs are driven in descending index order, which forces the merge to reorder them. A disabled input is held valid throughout one event to show it is ignored.

// File: rtl/pm_pkg.sv
package pm_pkg;

  typedef enum logic [1:0] {
    EM_IDLE = 2'd0,
    EM_HDR  = 2'd1,
    EM_DATA = 2'd2
  } em_state_t;

  localparam int HDR_IDX_POS = 16;

endpackage

// File: rtl/pm_evclock.sv
module pm_evclock #(
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            l1a,
  input  logic            complete,
  output logic [TS_W-1:0] ts_now,
  output logic [TS_W-1:0] cur_final,
  output logic [TS_W-1:0] prev_final
);

  logic [TS_W-1:0] tick_q;

  // the strobe cycle itself reads as time zero
  assign ts_now = l1a ? '0 : tick_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q <= '0;
    end else begin
      tick_q <= (&ts_now) ? ts_now : ts_now + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_final  <= '0;
      prev_final <= '0;
    end else if (l1a) begin
      prev_final <= cur_final;
      cur_final  <= complete ? ts_now : '0;
    end else if (complete) begin
      cur_final  <= ts_now;
    end
  end

endmodule

// File: rtl/pm_lane.sv
module pm_lane #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int TS_W   = 16,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              l1a,
  input  logic [TS_W-1:0]   ts_now,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  input  logic              pop,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic [CW-1:0]     count,
  output logic              fin,
  input  logic              release_i,
  output logic [TS_W-1:0]   cur_beg,
  output logic [TS_W-1:0]   cur_end,
  output logic [TS_W-1:0]   prev_beg,
  output logic [TS_W-1:0]   prev_end
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     fill_q;
  logic              done_q, in_pkt_q;
  logic              acc, cap_b;

  assign in_ready = en & ~done_q & (fill_q != CW'(DEPTH));
  assign acc      = in_valid & in_ready;
  assign fin      = acc & in_last;
  assign cap_b    = acc & ~in_pkt_q;
  assign done     = done_q;
  assign rd_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (acc) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill_q <= '0;
    end else begin
      if (acc) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({acc, pop})
        2'b10:   fill_q <= fill_q + 1'b1;
        2'b01:   fill_q <= fill_q - 1'b1;
        default: fill_q <= fill_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q   <= 1'b0;
      count    <= '0;
      in_pkt_q <= 1'b0;
    end else begin
      if (release_i) begin
        done_q <= 1'b0;
        count  <= '0;
      end else begin
        if (fin) done_q <= 1'b1;
        if (acc) count  <= count + 1'b1;
      end
      if (acc) in_pkt_q <= ~in_last;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_beg  <= '0;
      cur_end  <= '0;
      prev_beg <= '0;
      prev_end <= '0;
    end else if (l1a) begin
      prev_beg <= cur_beg;
      prev_end <= cur_end;
      cur_beg  <= cap_b ? ts_now : '0;
      cur_end  <= fin   ? ts_now : '0;
    end else begin
      if (cap_b) cur_beg <= ts_now;
      if (fin)   cur_end <= ts_now;
    end
  end

endmodule

// File: rtl/pm_emit.sv
module pm_emit
  import pm_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int DATA_W = 32,
  parameter int CW     = 5,
  parameter int IDX_W  = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_IN-1:0]          mask,
  input  logic [N_IN-1:0]          done,
  input  logic [N_IN*CW-1:0]       counts,
  input  logic [N_IN*DATA_W-1:0]   rd_flat,
  output logic [N_IN-1:0]          pop,
  output logic                     release_o,
  output logic [N_IN-1:0]          busy_mask,
  output logic                     out_valid,
  output logic [DATA_W-1:0]        out_data,
  output logic                     out_last
);

  em_state_t        st;
  logic [IDX_W-1:0] idx_q;
  logic [CW-1:0]    rem_q;
  logic [N_IN-1:0]  mask_q;
  logic             all_done;
  logic [CW-1:0]    sel_count;
  logic [DATA_W-1:0] sel_data, hdr;
  logic [IDX_W:0]   nxt, first;

  function automatic logic [IDX_W:0] first_from(input logic [N_IN-1:0] m, input int start);
    logic [IDX_W:0] r;
    r = '0;
    for (int k = N_IN - 1; k >= 0; k--) begin
      if (m[k] && k >= start) r = {1'b1, IDX_W'(k)};
    end
    return r;
  endfunction

  assign all_done  = (|mask) & (&(done | ~mask));
  assign sel_count = counts[idx_q*CW +: CW];
  assign sel_data  = rd_flat[idx_q*DATA_W +: DATA_W];
  assign nxt       = first_from(mask_q, int'(idx_q) + 1);
  assign first     = first_from(mask, 0);
  assign busy_mask = mask_q;

  always_comb begin
    hdr = '0;
    hdr[CW-1:0] = sel_count;
    hdr[HDR_IDX_POS +: IDX_W] = idx_q;
  end

  always_comb begin
    pop = '0;
    if (st == EM_DATA) pop[idx_q] = 1'b1;
  end

  assign release_o = (st == EM_DATA) && (rem_q == CW'(1)) && !nxt[IDX_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= EM_IDLE;
      idx_q     <= '0;
      rem_q     <= '0;
      mask_q    <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      case (st)
        EM_IDLE: begin
          if (all_done && first[IDX_W]) begin
            mask_q <= mask;
            idx_q  <= first[IDX_W-1:0];
            st     <= EM_HDR;
          end
        end
        EM_HDR: begin
          out_valid <= 1'b1;
          out_data  <= hdr;
          rem_q     <= sel_count;
          st        <= EM_DATA;
        end
        EM_DATA: begin
          out_valid <= 1'b1;
          out_data  <= sel_data;
          if (rem_q == CW'(1)) begin
            if (nxt[IDX_W]) begin
              idx_q <= nxt[IDX_W-1:0];
              st    <= EM_HDR;
            end else begin
              out_last <= 1'b1;
              mask_q   <= '0;
              st       <= EM_IDLE;
            end
          end else begin
            rem_q <= rem_q - 1'b1;
          end
        end
        default: st <= EM_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pkt_merger.sv
module pkt_merger #(
  parameter int N_IN   = 4,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int TS_W   = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_IN-1:0]        enable_mask,
  input  logic                   l1a,
  input  logic [N_IN-1:0]        in_valid,
  input  logic [N_IN*DATA_W-1:0] in_data,
  input  logic [N_IN-1:0]        in_last,
  output logic [N_IN-1:0]        in_ready,
  output logic                   out_valid,
  output logic [DATA_W-1:0]      out_data,
  output logic                   out_last,
  output logic [N_IN*TS_W-1:0]   cur_begin_ts,
  output logic [N_IN*TS_W-1:0]   cur_end_ts,
  output logic [N_IN*TS_W-1:0]   prev_begin_ts,
  output logic [N_IN*TS_W-1:0]   prev_end_ts,
  output logic [TS_W-1:0]        cur_final_ts,
  output logic [TS_W-1:0]        prev_final_ts
);

  localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1;
  localparam int CW    = $clog2(DEPTH + 1);

  logic [TS_W-1:0]        ts_now;
  logic [N_IN-1:0]        done, fin, pop, busy_mask;
  logic [N_IN*CW-1:0]     counts;
  logic [N_IN*DATA_W-1:0] rd_flat;
  logic                   release_w, complete;

  // the set completes in the cycle a finishing word closes the last open enabled input
  assign complete = (|fin) & (|enable_mask) & (&((done | fin) | ~enable_mask));

  pm_evclock #(.TS_W(TS_W)) u_clock (
    .clk(clk), .rst(rst), .l1a(l1a), .complete(complete),
    .ts_now(ts_now), .cur_final(cur_final_ts), .prev_final(prev_final_ts)
  );

  for (genvar g = 0; g < N_IN; g++) begin : g_lane
    pm_lane #(.DATA_W(DATA_W), .DEPTH(DEPTH), .TS_W(TS_W)) u_lane (
      .clk(clk), .rst(rst), .en(enable_mask[g]), .l1a(l1a), .ts_now(ts_now),
      .in_valid(in_valid[g]), .in_data(in_data[g*DATA_W +: DATA_W]),
      .in_last(in_last[g]), .in_ready(in_ready[g]),
      .pop(pop[g]), .rd_data(rd_flat[g*DATA_W +: DATA_W]),
      .done(done[g]), .count(counts[g*CW +: CW]), .fin(fin[g]),
      .release_i(release_w),
      .cur_beg(cur_begin_ts[g*TS_W +: TS_W]), .cur_end(cur_end_ts[g*TS_W +: TS_W]),
      .prev_beg(prev_begin_ts[g*TS_W +: TS_W]), .prev_end(prev_end_ts[g*TS_W +: TS_W])
    );
  end

  pm_emit #(.N_IN(N_IN), .DATA_W(DATA_W), .CW(CW), .IDX_W(IDX_W)) u_emit (
    .clk(clk), .rst(rst), .mask(enable_mask), .done(done), .counts(counts),
    .rd_flat(rd_flat), .pop(pop), .release_o(release_w), .busy_mask(busy_mask),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
  );

endmodule

// File: rtl/pkt_merger_chk.sv
module pkt_merger_chk #(
  parameter int N_IN = 4,
  parameter int TS_W = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic [N_IN-1:0]      enable_mask,
  input logic                 l1a,
  input logic [N_IN-1:0]      in_valid,
  input logic [N_IN-1:0]      in_last,
  input logic [N_IN-1:0]      in_ready,
  input logic                 out_valid,
  input logic                 out_last,
  input logic [TS_W-1:0]      ts_now,
  input logic [N_IN*TS_W-1:0] cur_begin_ts,
  input logic [N_IN*TS_W-1:0] prev_begin_ts,
  input logic [N_IN-1:0]      busy_mask
);

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    p_disabled_idle_r1: assert property (@(posedge clk) disable iff (rst)
      !enable_mask[i] |-> !in_ready[i]);

    p_hold_after_last_r2: assert property (@(posedge clk) disable iff (rst)
      (in_valid[i] && in_ready[i] && in_last[i]) |=> !in_ready[i]);

    p_inputs_held_r4: assert property (@(posedge clk) disable iff (rst)
      (out_valid && busy_mask[i]) |-> !in_ready[i]);

    p_shift_prev_r10: assert property (@(posedge clk) disable iff (rst)
      l1a |=> prev_begin_ts[i*TS_W +: TS_W] == $past(cur_begin_ts[i*TS_W +: TS_W]));
  end

  p_last_in_packet_r6: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  p_burst_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_last) |=> out_valid);

  p_tick_step_r7: assert property (@(posedge clk) disable iff (rst)
    (!(&ts_now)) |=> (l1a || ts_now == $past(ts_now) + 1'b1));

endmodule

bind pkt_merger pkt_merger_chk #(.N_IN(N_IN), .TS_W(TS_W)) u_chk (
  .clk(clk), .rst(rst), .enable_mask(enable_mask), .l1a(l1a),
  .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
  .out_valid(out_valid), .out_last(out_last), .ts_now(ts_now),
  .cur_begin_ts(cur_begin_ts), .prev_begin_ts(prev_begin_ts), .busy_mask(busy_mask)
);

// File: tb/sim_pkt_merger.sv
`timescale 1ns/1ps
module sim_pkt_merger;

  localparam int N  = 4;
  localparam int DW = 32;
  localparam int D  = 8;
  localparam int TW = 8;

  logic clk = 0, rst = 1, l1a = 0;
  logic [N-1:0] enable_mask = '0, vin = '0, vlast = '0, in_ready;
  logic [N*DW-1:0] vdata = '0;
  logic out_valid, out_last;
  logic [DW-1:0] out_data;
  logic [N*TW-1:0] cur_b, cur_e, prev_b, prev_e;
  logic [TW-1:0] cur_f, prev_f;

  always #2 clk = ~clk;

  pkt_merger #(.N_IN(N), .DATA_W(DW), .DEPTH(D), .TS_W(TW)) u0 (
    .clk(clk), .rst(rst), .enable_mask(enable_mask), .l1a(l1a),
    .in_valid(vin), .in_data(vdata), .in_last(vlast), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .cur_begin_ts(cur_b), .cur_end_ts(cur_e), .prev_begin_ts(prev_b),
    .prev_end_ts(prev_e), .cur_final_ts(cur_f), .prev_final_ts(prev_f)
  );

  typedef struct { logic [DW-1:0] d; logic l; } exp_t;
  exp_t exp_q[$];
  int n_chk = 0, n_bad = 0, cyc = 0, l1a_pos = 0;
  int exp_b[N], exp_e[N], exp_f;
  int sav_b[N], sav_e[N], sav_f;
  bit finished = 0;

  always @(posedge clk) cyc++;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic int sat(int x);
    return (x > 255) ? 255 : x;
  endfunction

  // monitor: pops expected words as the merged stream appears
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        check(0, "R12", "unexpected output word", out_data, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(out_data == e.d, "R5", "merged word", out_data, e.d);
        check(out_last == e.l, "R6", "out_last flag", out_last, e.l);
      end
    end
  end

  task automatic send_pkt(int i, int len, int evt);
    for (int k = 0; k < len; k++) begin
      vin[i] = 1'b1;
      vdata[i*DW +: DW] = {8'(i), 8'(evt), 16'(k)};
      vlast[i] = (k == len - 1);
      while (!in_ready[i]) @(negedge clk);
      if (k == 0) exp_b[i] = sat(cyc + 1 - l1a_pos);
      if (k == len - 1) begin
        exp_e[i] = sat(cyc + 1 - l1a_pos);
        exp_f = exp_e[i];
      end
      @(negedge clk);
    end
    vin[i] = 1'b0;
    vlast[i] = 1'b0;
  endtask

  task automatic run_event(logic [N-1:0] mask, int len[N], int evt, int pre_wait);
    int hi;
    int t;
    enable_mask = mask;
    l1a = 1'b1;
    l1a_pos = cyc + 1;
    @(negedge clk);
    l1a = 1'b0;
    sav_b = exp_b; sav_e = exp_e; sav_f = exp_f;
    for (int i = 0; i < N; i++) begin
      check(prev_b[i*TW +: TW] == TW'(sav_b[i]), "R10", "prev begin", prev_b[i*TW +: TW], sav_b[i]);
      check(prev_e[i*TW +: TW] == TW'(sav_e[i]), "R10", "prev end", prev_e[i*TW +: TW], sav_e[i]);
      check(cur_b[i*TW +: TW] == 0, "R10", "cur begin cleared", cur_b[i*TW +: TW], 0);
      exp_b[i] = 0; exp_e[i] = 0;
    end
    check(prev_f == TW'(sav_f), "R10", "prev final", prev_f, sav_f);
    exp_f = 0;
    hi = -1;
    for (int i = 0; i < N; i++) if (mask[i]) hi = i;
    for (int i = 0; i < N; i++) begin
      if (mask[i]) begin
        exp_q.push_back('{d: DW'((i << 16) | len[i]), l: 1'b0});
        for (int k = 0; k < len[i]; k++)
          exp_q.push_back('{d: {8'(i), 8'(evt), 16'(k)}, l: (i == hi && k == len[i] - 1)});
      end
    end
    repeat (pre_wait) @(negedge clk);
    for (int i = N - 1; i >= 0; i--) begin
      if (mask[i]) begin
        send_pkt(i, len[i], evt);
        if ((mask & ((N'(1) << i) - 1'b1)) != 0) begin
          check(!in_ready[i], "R2", "ready held after last", in_ready[i], 0);
          check(!out_valid, "R4", "output waits for all inputs", out_valid, 0);
        end
        if (len[i] == D)
          check(!in_ready[i], "R3", "ready low with full store", in_ready[i], 0);
      end
    end
    t = 0;
    while ((exp_q.size() != 0 || out_valid) && t < 200) begin
      @(negedge clk);
      t++;
    end
    check(exp_q.size() == 0, "R4", "one merged packet delivered", exp_q.size(), 0);
    for (int i = 0; i < N; i++) begin
      check(cur_b[i*TW +: TW] == TW'(exp_b[i]), mask[i] ? "R8" : "R1", "begin ts", cur_b[i*TW +: TW], exp_b[i]);
      check(cur_e[i*TW +: TW] == TW'(exp_e[i]), mask[i] ? "R8" : "R1", "end ts", cur_e[i*TW +: TW], exp_e[i]);
    end
    check(cur_f == TW'(exp_f), "R9", "final store ts", cur_f, exp_f);
  endtask

  initial begin
    #400000;
    check(0, "WATCHDOG", "run did not finish", 0, 1);
    finish_run();
  end

  initial begin
    int l[N];
    for (int i = 0; i < N; i++) begin exp_b[i] = 0; exp_e[i] = 0; end
    exp_f = 0;
    enable_mask = 4'hF;
    repeat (4) @(negedge clk);
    // R11: reset state
    check(!out_valid && !out_last, "R11", "outputs idle in reset", {out_valid, out_last}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready == 4'hF, "R11", "ready after reset", in_ready, 4'hF);
    check(cur_b == 0 && prev_e == 0 && cur_f == 0, "R11", "timestamps zero", cur_b, 0);

    // all four inputs, mixed lengths, one full-depth packet (R3)
    l = '{3, 1, D, 2};
    run_event(4'hF, l, 1, 3);

    // input 1 disabled but valid the whole time (R1)
    vin[1] = 1'b1;
    vdata[1*DW +: DW] = 32'hDEAD_BEEF;
    vlast[1] = 1'b1;
    l = '{2, 4, 1, 5};
    run_event(4'b1101, l, 2, 2);
    check(!in_ready[1], "R1", "disabled input not ready", in_ready[1], 0);
    vin[1] = 1'b0;
    vlast[1] = 1'b0;

    // single input, no wait
    l = '{1, 1, 6, 1};
    run_event(4'b0100, l, 3, 0);

    // saturation of the timer (R7)
    l = '{2, 2, 2, 2};
    run_event(4'b1010, l, 4, 300);
    check(cur_b[3*TW +: TW] == 8'hFF, "R7", "timer saturates", cur_b[3*TW +: TW], 8'hFF);

    // nothing enabled (R12)
    l = '{1, 1, 1, 1};
    run_event(4'b0000, l, 5, 5);
    repeat (20) @(negedge clk);
    check(!out_valid, "R12", "no output when none enabled", out_valid, 0);

    // two inputs back to back, previous set shows empty event (R10)
    l = '{4, 3, 1, 1};
    run_event(4'b0011, l, 6, 1);
    l = '{1, 1, 1, 1};
    run_event(4'b0001, l, 7, 0);

    finish_run();
  end

endmodule